// File: doc/BRIEF.md
# Fetch Address Translation Cache

This block sits right after the instruction-fetch address selector. It turns each effective fetch address into a real address, using two fully associative page entries. Each entry holds an effective page number and the real page number that goes with it. A direct-mapped translation table of parameterised depth backs the two entries. When both entries miss, the block reads that table, spending a fixed two-cycle bubble on it. The result goes into the least recently used entry, and the fetch then proceeds as a normal hit.

If the table also misses, or its entry denies execution, the block raises a fault flag and holds the fetch. It stays there until the memory-management unit delivers a page-table entry, or until the fetch side redirects. An invalidate strobe wipes every cached translation. When translation is disabled, the effective address is passed straight through.

The fetch address arrives on a valid/ready stream. While `fa_valid` is high and `fa_ready` is low, the requester must hold `fa_ea` and `xlate_on` stable. A transfer happens on every clock edge where both are high. `fa_ready` depends on the presented address, because it is high only when the address can be translated in the same cycle. The translated output has no back-pressure: `ra_valid` pulses for one cycle, exactly one cycle after each transfer.

Top module: `fetch_xlate_cache`

## Requirements
- R1: An accepted fetch whose page matches a valid entry is taken in the same cycle it is presented (`fa_ready` high, no bubble). The output real address is that entry's real page number above the 12-bit page offset. At most one entry ever matches a given page.
- R2: Pages are 4 KiB: bits 11:0 of `ra_addr` equal bits 11:0 of the accepted `fa_ea`. `ra_valid` is high in exactly the cycle after each transfer and low otherwise.
- R3: With translation on, a page that matches no entry but does match a permitted table slot keeps `fa_ready` low for exactly two cycles, with `ra_valid` low throughout. After that the fetch is accepted and translated.
- R4: A single LRU pointer selects the entry to refill. It points away from the entry last matched by an accepted fetch, or last filled. Both fills from the table and fills from a page-table entry use it.
- R5: With `xlate_on` low, the fetch is accepted at once and `ra_addr` equals `fa_ea` unchanged, whatever the cached state.
- R6: The table is direct-mapped. Effective page-number bit b (address bit 12+b) is XORed into index bit b mod log2(depth). A write to a slot replaces its previous page.
- R7: If the table slot misses, or holds the page with execute permission clear, `fault` rises in the second cycle after the fetch is presented, with `fa_ready` held low. It stays high until `pte_valid` (the entry is written into the table and, when `pte_xok` is set, into the LRU entry) or `redirect`.
- R8: A one-cycle `inval` clears the valid state of both entries and of every table slot, so the next translated fetch of any page faults.
- R9: After reset, both entries and all table slots are invalid, `ra_valid` and `fault` are low, and `ra_addr` is zero.
- R10: `pte_valid` outside the fault state writes only the table slot, so the next fetch of that page takes the two-cycle path of R3. If that slot has `pte_xok` clear, the fetch faults instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fa_valid | input | 1 | Fetch address presented |
| fa_ready | output | 1 | Fetch address taken this cycle |
| fa_ea | input | EA_W | Effective fetch address |
| xlate_on | input | 1 | Translation enabled for this fetch |
| ra_valid | output | 1 | Translated address valid (one cycle after transfer) |
| ra_addr | output | EA_W | Real fetch address |
| fault | output | 1 | Translation fault, fetch held |
| redirect | input | 1 | Fetch redirected; releases a fault |
| pte_valid | input | 1 | Page-table entry delivered by the MMU |
| pte_epn | input | EA_W-12 | Effective page number of the delivered entry |
| pte_rpn | input | EA_W-12 | Real page number of the delivered entry |
| pte_xok | input | 1 | Execute permission of the delivered entry |
| inval | input | 1 | Invalidate all cached translations |

## Verification
A wrong LRU pointer or entry content shows up at the ports within the next few fetches. A page expected to hit costs a two-cycle bubble, or a page expected to miss is accepted at once with a stale real page. A table index fault appears as a fault in place of the two-cycle path, or as a slot that survives a conflicting write. The bench keeps a model of both entries, the LRU pointer and the table, and predicts three things for every fetch: the exact number of stalled cycles, whether `fault` rises, and the real address. A divergence is therefore caught on the first fetch that touches the corrupted state.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FAULT = 2'd2
  } fxc_state_e;
endpackage

// File: rtl/fxc_entries.sv
module fxc_entries #(
  parameter int PN_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PN_W-1:0] lk_epn,
  input  logic            flush,
  input  logic            touch,
  input  logic            fill,
  input  logic [PN_W-1:0] fill_epn,
  input  logic [PN_W-1:0] fill_rpn,
  output logic            hit,
  output logic [PN_W-1:0] hit_rpn,
  output logic [1:0]      hit_vec,
  output logic [1:0]      vld
);
  localparam int NENT = 2;

  logic [PN_W-1:0] epn_q [NENT];
  logic [PN_W-1:0] rpn_q [NENT];
  logic [1:0]      v_q;
  logic            lru_q;

  generate
    for (genvar g = 0; g < NENT; g++) begin : g_cmp
      assign hit_vec[g] = v_q[g] && (epn_q[g] == lk_epn);
    end
  endgenerate

  assign hit     = |hit_vec;
  assign hit_rpn = hit_vec[1] ? rpn_q[1] : rpn_q[0];
  assign vld     = v_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NENT; i++) begin
      if (fill && !flush && (lru_q == i[0])) begin
        epn_q[i] <= fill_epn;
        rpn_q[i] <= fill_rpn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      lru_q <= 1'b0;
    end else if (flush) begin
      v_q <= '0;
    end else if (fill) begin
      v_q[lru_q] <= 1'b1;
      lru_q      <= ~lru_q;
    end else if (touch && hit) begin
      lru_q <= ~hit_vec[1];
    end
  end
endmodule

// File: rtl/fxc_tlb.sv
module fxc_tlb #(
  parameter int PN_W  = 20,
  parameter int DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            rd_en,
  input  logic [PN_W-1:0] rd_epn,
  input  logic            wr_en,
  input  logic [PN_W-1:0] wr_epn,
  input  logic [PN_W-1:0] wr_rpn,
  input  logic            wr_xok,
  output logic            rd_hit,
  output logic            rd_xok,
  output logic [PN_W-1:0] rd_rpn
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [IDX_W-1:0] fold(input logic [PN_W-1:0] e);
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < PN_W; b++) acc[b % IDX_W] = acc[b % IDX_W] ^ e[b];
    return acc;
  endfunction

  logic [PN_W-1:0]  tag_m [DEPTH];
  logic [PN_W-1:0]  rpn_m [DEPTH];
  logic             xok_m [DEPTH];
  logic [DEPTH-1:0] v_q;

  logic [PN_W-1:0]  q_tag, q_want, q_rpn;
  logic             q_x, q_v;

  logic [IDX_W-1:0] ri, wi;
  assign ri = fold(rd_epn);
  assign wi = fold(wr_epn);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[wi] <= wr_epn;
      rpn_m[wi] <= wr_rpn;
      xok_m[wi] <= wr_xok;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      q_tag  <= tag_m[ri];
      q_rpn  <= rpn_m[ri];
      q_x    <= xok_m[ri];
      q_want <= rd_epn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      q_v <= 1'b0;
    end else begin
      if (flush)      v_q     <= '0;
      else if (wr_en) v_q[wi] <= 1'b1;
      if (rd_en)      q_v     <= v_q[ri] && !flush;
    end
  end

  assign rd_hit = q_v && (q_tag == q_want);
  assign rd_xok = q_x;
  assign rd_rpn = q_rpn;
endmodule

// File: rtl/fxc_ctrl.sv
module fxc_ctrl
  import fxc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fa_valid,
  input  logic xlate_on,
  input  logic ent_hit,
  input  logic tlb_hit,
  input  logic tlb_xok,
  input  logic pte_valid,
  input  logic pte_xok,
  input  logic redirect,
  input  logic inval,
  output logic fa_ready,
  output logic accept,
  output logic tlb_rd,
  output logic fill_tlb,
  output logic fill_pte,
  output logic in_fault
);
  fxc_state_e st_q, st_d;

  assign fa_ready = (st_q == ST_IDLE) && (!xlate_on || ent_hit);
  assign accept   = fa_valid && fa_ready;
  assign tlb_rd   = (st_q == ST_IDLE) && fa_valid && xlate_on && !ent_hit;
  assign fill_tlb = (st_q == ST_LOOK) && !inval && tlb_hit && tlb_xok;
  assign fill_pte = (st_q == ST_FAULT) && pte_valid && pte_xok;
  assign in_fault = (st_q == ST_FAULT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (tlb_rd) st_d = ST_LOOK;
      ST_LOOK:  st_d = (inval || (tlb_hit && tlb_xok)) ? ST_IDLE : ST_FAULT;
      ST_FAULT: if (pte_valid || redirect) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/fetch_xlate_cache.sv
module fetch_xlate_cache #(
  parameter int EA_W      = 32,
  parameter int TLB_DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fa_valid,
  output logic               fa_ready,
  input  logic [EA_W-1:0]    fa_ea,
  input  logic               xlate_on,
  output logic               ra_valid,
  output logic [EA_W-1:0]    ra_addr,
  output logic               fault,
  input  logic               redirect,
  input  logic               pte_valid,
  input  logic [EA_W-13:0]   pte_epn,
  input  logic [EA_W-13:0]   pte_rpn,
  input  logic               pte_xok,
  input  logic               inval
);
  localparam int PG_W = 12;
  localparam int PN_W = EA_W - PG_W;

  logic [PN_W-1:0] cur_epn, hit_rpn, tlb_rpn, fill_epn, fill_rpn;
  logic            ent_hit, tlb_hit, tlb_xok;
  logic            accept, tlb_rd, fill_tlb, fill_pte, in_fault;
  logic [1:0]      hit_vec, ent_vld;

  assign cur_epn  = fa_ea[EA_W-1:PG_W];
  assign fill_epn = fill_pte ? pte_epn : cur_epn;
  assign fill_rpn = fill_pte ? pte_rpn : tlb_rpn;

  fxc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fa_valid(fa_valid), .xlate_on(xlate_on),
    .ent_hit(ent_hit), .tlb_hit(tlb_hit), .tlb_xok(tlb_xok),
    .pte_valid(pte_valid), .pte_xok(pte_xok), .redirect(redirect), .inval(inval),
    .fa_ready(fa_ready), .accept(accept), .tlb_rd(tlb_rd),
    .fill_tlb(fill_tlb), .fill_pte(fill_pte), .in_fault(in_fault)
  );

  fxc_entries #(.PN_W(PN_W)) u_ent (
    .clk(clk), .rst_n(rst_n), .lk_epn(cur_epn), .flush(inval),
    .touch(accept && xlate_on), .fill(fill_tlb || fill_pte),
    .fill_epn(fill_epn), .fill_rpn(fill_rpn),
    .hit(ent_hit), .hit_rpn(hit_rpn), .hit_vec(hit_vec), .vld(ent_vld)
  );

  fxc_tlb #(.PN_W(PN_W), .DEPTH(TLB_DEPTH)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(inval),
    .rd_en(tlb_rd), .rd_epn(cur_epn),
    .wr_en(pte_valid), .wr_epn(pte_epn), .wr_rpn(pte_rpn), .wr_xok(pte_xok),
    .rd_hit(tlb_hit), .rd_xok(tlb_xok), .rd_rpn(tlb_rpn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_valid <= 1'b0;
      ra_addr  <= '0;
    end else begin
      ra_valid <= accept;
      if (accept) ra_addr <= xlate_on ? {hit_rpn, fa_ea[PG_W-1:0]} : fa_ea;
    end
  end

  assign fault = in_fault;
endmodule

// File: rtl/fetch_xlate_cache_chk.sv
module fetch_xlate_cache_chk #(
  parameter int EA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fa_valid,
  input logic            fa_ready,
  input logic [EA_W-1:0] fa_ea,
  input logic            xlate_on,
  input logic            ra_valid,
  input logic [EA_W-1:0] ra_addr,
  input logic            fault,
  input logic            redirect,
  input logic            pte_valid,
  input logic            inval,
  input logic [1:0]      ent_vld,
  input logic [1:0]      hit_vec
);
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fa_valid && fa_ready |=> ra_valid && (ra_addr[11:0] == $past(fa_ea[11:0])));

  a_r2_valid_only_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    ra_valid |-> $past(fa_valid && fa_ready));

  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    fa_valid && fa_ready && !xlate_on |=> ra_addr == $past(fa_ea));

  a_r7_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !pte_valid && !redirect |=> fault);

  a_r7_fault_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(!fa_ready));

  a_r8_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> ent_vld == 2'b00);
endmodule

bind fetch_xlate_cache fetch_xlate_cache_chk #(.EA_W(EA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fa_valid(fa_valid), .fa_ready(fa_ready),
  .fa_ea(fa_ea), .xlate_on(xlate_on), .ra_valid(ra_valid), .ra_addr(ra_addr),
  .fault(fault), .redirect(redirect), .pte_valid(pte_valid), .inval(inval),
  .ent_vld(ent_vld), .hit_vec(hit_vec)
);

// File: tb/fetch_xlate_cache_test.sv
`timescale 1ns/1ps
module fetch_xlate_cache_test;
  localparam int EA_W = 32;
  localparam int PN_W = 20;
  localparam int DEP  = 64;

  logic clk = 0, rst_n = 0;
  logic fa_valid = 0, fa_ready, xlate_on = 0, ra_valid, fault;
  logic redirect = 0, pte_valid = 0, pte_xok = 0, inval = 0;
  logic [EA_W-1:0] fa_ea = '0, ra_addr;
  logic [PN_W-1:0] pte_epn = '0, pte_rpn = '0;

  always #2.5 clk = ~clk;

  fetch_xlate_cache #(.EA_W(EA_W), .TLB_DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .fa_valid(fa_valid), .fa_ready(fa_ready),
    .fa_ea(fa_ea), .xlate_on(xlate_on), .ra_valid(ra_valid), .ra_addr(ra_addr),
    .fault(fault), .redirect(redirect), .pte_valid(pte_valid),
    .pte_epn(pte_epn), .pte_rpn(pte_rpn), .pte_xok(pte_xok), .inval(inval)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic            m_v [2];
  logic [PN_W-1:0] m_e [2];
  logic            m_lru;
  logic            t_v [DEP];
  logic [PN_W-1:0] t_e [DEP];
  logic            t_x [DEP];

  function automatic logic [5:0] hsh(input logic [PN_W-1:0] e);
    logic [5:0] a = '0;
    for (int b = 0; b < PN_W; b++) a[b % 6] = a[b % 6] ^ e[b];
    return a;
  endfunction
  function automatic logic [PN_W-1:0] pt_rpn(input logic [PN_W-1:0] e);
    return e ^ 20'h3C5A1;
  endfunction
  function automatic logic pt_x(input logic [PN_W-1:0] e);
    return e[2:0] != 3'd7;
  endfunction
  // 0 = entry hit, 1 = table path, 2 = fault
  function automatic int predict(input logic [PN_W-1:0] e);
    logic [5:0] h = hsh(e);
    if ((m_v[0] && m_e[0] == e) || (m_v[1] && m_e[1] == e)) return 0;
    if (t_v[h] && t_e[h] == e && t_x[h]) return 1;
    return 2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_fill(input logic [PN_W-1:0] e);
    m_v[m_lru] = 1; m_e[m_lru] = e; m_lru = ~m_lru;
  endtask

  task automatic do_inval();
    @(negedge clk); inval = 1;
    @(negedge clk); inval = 0;
    for (int i = 0; i < 2; i++) m_v[i] = 0;
    for (int i = 0; i < DEP; i++) t_v[i] = 0;
  endtask

  task automatic preload(input logic [PN_W-1:0] e);
    @(negedge clk); pte_valid = 1; pte_epn = e; pte_rpn = pt_rpn(e); pte_xok = pt_x(e);
    @(negedge clk); pte_valid = 0;
    t_v[hsh(e)] = 1; t_e[hsh(e)] = e; t_x[hsh(e)] = pt_x(e);
  endtask

  task automatic fetch(input logic [EA_W-1:0] ea, input bit xl, input string req);
    logic [PN_W-1:0] e = ea[31:12];
    int exp = xl ? predict(e) : 0;
    int waits = 0;
    bit faulted = 0;
    @(negedge clk); xlate_on = xl; fa_valid = 1; fa_ea = ea; #1;
    while (!fa_ready) begin
      chk(!ra_valid, "R3 output idle during stall", 32'(ra_valid), 0);
      @(negedge clk); #1; waits++;
      if (fault) begin
        chk(exp == 2 && waits == 2, "R7 fault timing", 32'(waits), 2);
        if (pt_x(e)) begin
          pte_valid = 1; pte_epn = e; pte_rpn = pt_rpn(e); pte_xok = 1;
          @(negedge clk); pte_valid = 0; #1;
          t_v[hsh(e)] = 1; t_e[hsh(e)] = e; t_x[hsh(e)] = 1;
          m_fill(e);
          faulted = 1;
          chk(!fault && fa_ready, "R7 released by pte", 32'(fault), 0);
        end else begin
          redirect = 1; fa_valid = 0;
          @(negedge clk); redirect = 0; #1;
          chk(!fault, "R7 released by redirect", 32'(fault), 0);
          return;
        end
      end
      if (waits > 20) begin
        chk(0, "R3 stall too long", 32'(waits), 32'(exp));
        fa_valid = 0;
        return;
      end
    end
    if (!faulted) begin
      chk(exp != 2, "R7 expected fault missing", 0, 1);
      chk(waits == (exp == 1 ? 2 : 0), exp == 1 ? "R3 table path latency" : "R1 hit latency",
          32'(waits), exp == 1 ? 2 : 0);
      if (xl) begin
        if (exp == 1) m_fill(e);
        else if (m_v[1] && m_e[1] == e) m_lru = 0;
        else m_lru = 1;
      end
    end
    @(negedge clk); fa_valid = 0; #1;
    chk(ra_valid, "R2 output valid after transfer", 32'(ra_valid), 1);
    if (!xl) chk(ra_addr == ea, "R5 bypass address", ra_addr, ea);
    else chk(ra_addr == {pt_rpn(e), ea[11:0]}, req, ra_addr, {pt_rpn(e), ea[11:0]});
    @(negedge clk); #1;
    chk(!ra_valid, "R2 single output pulse", 32'(ra_valid), 0);
  endtask

  logic [PN_W-1:0] pool [8];

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) m_v[i] = 0;
    for (int i = 0; i < DEP; i++) t_v[i] = 0;
    m_lru = 0;
    pool[0] = 20'h00001; pool[1] = 20'h00040; pool[2] = 20'h12345; pool[3] = 20'h00007;
    pool[4] = 20'h0ABC0; pool[5] = 20'h00002; pool[6] = 20'h31330; pool[7] = 20'h00081;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R9 reset state
    chk(!ra_valid && !fault && ra_addr == 0, "R9 reset outputs", ra_addr, 0);
    chk(fa_ready, "R9 ready with translation off", 32'(fa_ready), 1);
    xlate_on = 1; fa_ea = 32'h0000_1000; #1;
    chk(!fa_ready, "R9 entries empty after reset", 32'(fa_ready), 0);
    xlate_on = 0;
    // R5 pass-through
    fetch(32'hDEAD_BEEF, 0, "R5");
    fetch(32'h0000_7FFC, 0, "R5");
    // R7 fault then fill; R1 hit afterwards
    fetch(32'h0000_1234, 1, "R7 fill translation");
    fetch(32'h0000_1FF8, 1, "R1 hit translation");
    // R4 LRU order
    fetch(32'h0004_0010, 1, "R4 second fill");
    fetch(32'h0000_1004, 1, "R4 hit first");
    preload(20'h12345);
    fetch(32'h1234_5ABC, 1, "R10 preload then table path");
    fetch(32'h0000_1008, 1, "R4 recent entry kept");
    fetch(32'h0004_0020, 1, "R4 evicted entry via table");
    // R7 protection fault via preloaded non-exec page, R10
    preload(20'h00007);
    fetch(32'h0000_7000, 1, "R10 non-exec");
    // R6 slot conflict: 00001 and 00040 share a slot
    fetch(32'h0ABC_0000, 1, "R6 fill");
    fetch(32'h0000_2000, 1, "R6 fill");
    fetch(32'h0000_1000, 1, "R6 conflict slot");
    // R8 invalidate
    fetch(32'h0000_1010, 1, "R8 before inval");
    do_inval();
    fetch(32'h0000_1010, 1, "R8 after inval");
    // random mix
    for (int n = 0; n < 300; n++) begin
      int r = $urandom % 20;
      logic [PN_W-1:0] e = pool[$urandom % 8];
      if (r == 0) do_inval();
      else if (r == 1) preload(e);
      else fetch({e, 12'($urandom)}, ($urandom % 8) != 0, "R1 random translation");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule